// File: doc/BRIEF.md
# Breathing PWM LED Dimmer

This block produces one pulse-width-modulated output for an LED. Software sets it up through two 32-bit parameter words on a plain write/read port. A free-running counter steps through each period. The output is high from the start of the period until the counter reaches a duty threshold.

The threshold has two sources. In fixed mode it comes from a register. In sweep mode it moves up and down by one count per period between a programmable lower and upper bound, so the LED appears to breathe. Changes to the period and the fixed threshold wait for the next period boundary, so no pulse is ever cut short or stretched.

Software is expected to keep 1 < threshold < period and 1 < lower bound < upper bound < period. Sweep bounds should only be changed while the sweep is off.

Top module: `pwm_breathe_dimmer`

## Requirements
- R1: After reset the output is low and both parameter words read back as zero; the sweep is off.
- R2: Word index 0 holds the period in bits [31:16] and the fixed threshold in bits [15:0]. Word index 1 holds the sweep enable in bit 31, the lower bound in bits [30:16] and the upper bound in bits [15:0]. Reads return the stored word. Writes to any other index change nothing, and reads of other indices return zero.
- R3: With period P ≥ 2 the counter runs from 0 to P−1 and wraps. The output is high while the counter is below the active threshold, so each period carries exactly that many high cycles.
- R4: An active period of 0 or 1 holds the output low.
- R5: A new period or fixed threshold takes effect only at the next period boundary. The period in progress completes with its old length and duty.
- R6: While the sweep is on, the fixed threshold has no effect; the swept value sets the duty.
- R7: Writing word 1 with bit 31 set while the sweep is off restarts the sweep at the lower bound, heading upward. The following full period has lower bound + 1 high cycles.
- R8: While the sweep is on, the swept value changes by exactly one at each period boundary. It rises to the upper bound, then falls to the lower bound, and repeats.
- R9: Clearing bit 31 of word 1 returns the duty to the active fixed threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the parameter port |
| reg_addr | input | ADDR_W (2) | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
A parameter write is sampled at a clock edge and appears on reg_rdata right after that edge. It reaches pwm_out only through the next period boundary. The exception is the sweep enable, which changes the duty source after that same edge. The bench keeps a behavioural model that takes the same inputs at each rising edge and compares output and read data at every falling edge, so each result is checked in the cycle it is due. Period lengths and high counts are measured between rising edges of the output, which makes the duty and sweep checks independent of where in a period a write landed.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int LO_W   = 15;

    localparam int IDX_FIXED = 0;
    localparam int IDX_SWEEP = 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // layout of word 0: period in the upper half, fixed threshold in the lower
    typedef struct packed {
        cnt_t period;
        cnt_t thresh;
    } fixed_cfg_t;

    // layout of word 1: enable on top, lower bound, upper bound
    typedef struct packed {
        logic            en;
        logic [LO_W-1:0] lo;
        cnt_t            hi;
    } sweep_cfg_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_t;

    function automatic cnt_t lo_ext(input logic [LO_W-1:0] v);
        return cnt_t'(v);
    endfunction

    function automatic logic period_runs(input cnt_t p);
        return p > cnt_t'(1);
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_dim_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output fixed_cfg_t          fcfg,
    output sweep_cfg_t          scfg,
    output logic                restart,
    output logic [DATA_W-1:0]   rdata
);

    logic hit_fixed;
    logic hit_sweep;

    assign hit_fixed = (addr == ADDR_W'(IDX_FIXED));
    assign hit_sweep = (addr == ADDR_W'(IDX_SWEEP));

    // sweep restarts only on an off-to-on transition
    assign restart = we && hit_sweep && wdata[DATA_W-1] && !scfg.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcfg <= '0;
            scfg <= '0;
        end else if (we) begin
            if (hit_fixed) fcfg <= fixed_cfg_t'(wdata);
            if (hit_sweep) scfg <= sweep_cfg_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_fixed) rdata = DATA_W'(fcfg);
        if (hit_sweep) rdata = DATA_W'(scfg);
    end

    AST_RESTART_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
        restart |=> scfg.en); // R7

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fixed_cfg_t fcfg,
    output cnt_t       cnt,
    output cnt_t       act_period,
    output cnt_t       act_thresh,
    output logic       boundary
);

    assign boundary = !period_runs(act_period) || (cnt == act_period - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            act_period <= '0;
            act_thresh <= '0;
        end else if (boundary) begin
            cnt        <= '0;
            act_period <= fcfg.period;
            act_thresh <= fcfg.thresh;
        end else begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        period_runs(act_period) |-> cnt < act_period); // R3

    AST_SHORT_PERIOD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !period_runs(act_period) |=> cnt == '0); // R4

    AST_NO_MIDPERIOD_LOAD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(act_period) && $stable(act_thresh)); // R5

endmodule

// File: rtl/pwm_sweep_gen.sv
module pwm_sweep_gen
    import pwm_dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sweep_cfg_t scfg,
    input  logic       restart,
    input  cnt_t       restart_lo,
    input  logic       boundary,
    output cnt_t       sweep_val
);

    sweep_dir_t dir;
    cnt_t       lo_now;

    assign lo_now = lo_ext(scfg.lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_val <= '0;
            dir       <= DIR_UP;
        end else if (restart) begin
            sweep_val <= restart_lo;
            dir       <= DIR_UP;
        end else if (scfg.en && boundary) begin
            unique case (dir)
                DIR_UP: begin
                    if (sweep_val >= scfg.hi) begin
                        sweep_val <= sweep_val - cnt_t'(1);
                        dir       <= DIR_DOWN;
                    end else begin
                        sweep_val <= sweep_val + cnt_t'(1);
                    end
                end
                DIR_DOWN: begin
                    if (sweep_val <= lo_now) begin
                        sweep_val <= sweep_val + cnt_t'(1);
                        dir       <= DIR_UP;
                    end else begin
                        sweep_val <= sweep_val - cnt_t'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !restart) |=> $stable(sweep_val)); // R8

    AST_SWEEP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (scfg.en && boundary && !restart) |=>
            (sweep_val == cnt_t'($past(sweep_val) + cnt_t'(1))) ||
            (sweep_val == cnt_t'($past(sweep_val) - cnt_t'(1)))); // R8

    AST_SWEEP_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> sweep_val == $past(restart_lo)); // R7

endmodule

// File: rtl/pwm_breathe_dimmer.sv
module pwm_breathe_dimmer
    import pwm_dim_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                pwm_out
);

    fixed_cfg_t fcfg;
    sweep_cfg_t scfg;
    logic       restart;
    cnt_t       cnt;
    cnt_t       act_period;
    cnt_t       act_thresh;
    logic       boundary;
    cnt_t       sweep_val;
    cnt_t       duty;
    sweep_cfg_t wr_sweep;

    assign wr_sweep = sweep_cfg_t'(reg_wdata);

    pwm_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .fcfg    (fcfg),
        .scfg    (scfg),
        .restart (restart),
        .rdata   (reg_rdata)
    );

    pwm_period_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .fcfg       (fcfg),
        .cnt        (cnt),
        .act_period (act_period),
        .act_thresh (act_thresh),
        .boundary   (boundary)
    );

    pwm_sweep_gen u_sweep (
        .clk        (clk),
        .rst        (rst),
        .scfg       (scfg),
        .restart    (restart),
        .restart_lo (lo_ext(wr_sweep.lo)),
        .boundary   (boundary),
        .sweep_val  (sweep_val)
    );

    assign duty    = scfg.en ? sweep_val : act_thresh;
    assign pwm_out = period_runs(act_period) && (cnt < duty);

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm_out) && $stable(scfg.en)) |-> cnt == '0); // R3

    AST_LOW_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!period_runs(fcfg.period) && boundary) |=> !pwm_out); // R4

endmodule

// File: tb/sim_pwm_breathe_dimmer.sv
module sim_pwm_breathe_dimmer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    pwm_breathe_dimmer u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // behavioural reference
    int          m_cnt, m_ap, m_at, m_rv;
    bit          m_up;
    logic [31:0] m_w0, m_w1;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_ap = 0; m_at = 0; m_rv = 0; m_up = 1;
            m_w0 = '0; m_w1 = '0;
        end else begin
            bit was_en;
            int lo, hi;
            bit at_end;
            was_en = m_w1[31];
            lo = int'(m_w1[30:16]);
            hi = int'(m_w1[15:0]);
            at_end = (m_ap < 2) || (m_cnt == m_ap - 1);
            if (reg_we && reg_addr == 2'd1 && reg_wdata[31] && !was_en) begin
                m_rv = int'(reg_wdata[30:16]); m_up = 1;
            end else if (was_en && at_end) begin
                if (m_up) begin
                    if (m_rv >= hi) begin m_rv--; m_up = 0; end else m_rv++;
                end else begin
                    if (m_rv <= lo) begin m_rv++; m_up = 1; end else m_rv--;
                end
            end
            if (at_end) begin
                m_cnt = 0; m_ap = int'(m_w0[31:16]); m_at = int'(m_w0[15:0]);
            end else begin
                m_cnt++;
            end
            if (reg_we && reg_addr == 2'd0) m_w0 = reg_wdata;
            if (reg_we && reg_addr == 2'd1) m_w1 = reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic        e_out;
            logic [31:0] e_rd;
            e_out = (m_ap >= 2) && (m_cnt < (m_w1[31] ? m_rv : m_at));
            e_rd  = (reg_addr == 2'd0) ? m_w0 : (reg_addr == 2'd1) ? m_w1 : 32'd0;
            n_chk++;
            if (pwm_out !== e_out) begin
                n_bad++;
                $display("FAIL %s cycle %0d pwm_out actual %b expected %b", phase, cyc, pwm_out, e_out);
            end
            n_chk++;
            if (reg_rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s cycle %0d rdata actual %h expected %h", phase, cyc, reg_rdata, e_rd);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic sync_rise();
        logic prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    // call at a rising-edge sample; returns at the next one
    task automatic measure(output int len, output int hi);
        logic prev;
        len = 1; hi = 1; prev = 1'b1;
        forever begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            len++;
            if (pwm_out) hi++;
            prev = pwm_out;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int len, hi, c0, mn, mx, prevh, span;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1 out", int'(pwm_out), 0);
        rd(2'd0, d); check("R1 word0", int'(d), 0);
        rd(2'd1, d); check("R1 word1", int'(d), 0);

        // R2: register layout and ignored indices
        phase = "R2";
        wr(2'd0, {16'd8, 16'd3});
        wr(2'd1, {1'b0, 15'd2, 16'd6});
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h1234_5678);
        rd(2'd0, d); check("R2 word0", int'(d), int'({16'd8, 16'd3}));
        rd(2'd1, d); check("R2 word1", int'(d), int'({1'b0, 15'd2, 16'd6}));
        rd(2'd2, d); check("R2 idx2", int'(d), 0);
        rd(2'd3, d); check("R2 idx3", int'(d), 0);

        // R3: period 8, duty 3
        phase = "R3";
        sync_rise();
        for (int i = 0; i < 2; i++) begin
            measure(len, hi);
            check("R3 length", len, 8);
            check("R3 high", hi, 3);
        end

        // R5: mid-period update waits for the boundary
        phase = "R5";
        c0 = cyc;
        wr(2'd0, {16'd12, 16'd5});
        sync_rise();
        check("R5 old period kept", cyc - c0, 8);
        measure(len, hi);
        check("R5 new length", len, 12);
        check("R5 new high", hi, 5);

        // R7: enable the sweep right after a period start
        phase = "R7";
        wr(2'd1, {1'b1, 15'd2, 16'd6});
        rd(2'd1, d); check("R7 enable readback", int'(d[31]), 1);
        sync_rise();
        measure(len, hi);
        check("R7 first period high", hi, 3);

        // R6 and R8: fixed threshold ignored, triangle sweep
        phase = "R8";
        wr(2'd0, {16'd12, 16'd9});
        sync_rise();
        mn = 100; mx = 0; prevh = -1;
        span = 6 - 2;
        for (int k = 0; k < 12; k++) begin
            measure(len, hi);
            check("R6 length", len, 12);
            n_chk++;
            if (hi == 9) begin
                n_bad++;
                $display("FAIL R6 high actual %0d expected not 9", hi);
            end
            if (prevh >= 0) begin
                int dlt;
                dlt = hi - prevh;
                check("R8 unit step", (dlt == 1 || dlt == -1) ? 1 : 0, 1);
            end
            if (hi < mn) mn = hi;
            if (hi > mx) mx = hi;
            prevh = hi;
        end
        check("R8 lowest", mn, 2);
        check("R8 highest", mx, 2 + span);

        // R9: sweep off returns to fixed threshold 9
        phase = "R9";
        wr(2'd1, {1'b0, 15'd2, 16'd6});
        sync_rise();
        measure(len, hi);
        check("R9 length", len, 12);
        check("R9 high", hi, 9);

        // R4: period 1 and period 0 hold the output low
        phase = "R4";
        wr(2'd0, {16'd1, 16'd1});
        repeat (15) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R4 period1 highs", hi, 0);
        wr(2'd0, {16'd0, 16'd4});
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R4 period0 highs", hi, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule